// File: doc/BRIEF.md
# CMOS Index/Data Port Router

This block sits behind a two-location bus window and works like the classic PC CMOS register pair. The even location holds an 8-bit index. The odd location moves a byte to or from whatever the index selects. The bus side carries one address bit, separate read and write strobes, and a byte in each direction.

The index value decides where a data access goes:

- **Low indices** (0x00 through `RTC_LAST`, default 0x0D) select registers of an external real-time-clock chip. The block forwards those accesses through its own strobes, which have a single address bit.
- **Higher indices** select a local 256-byte RAM, cleared at reset.

A write of a low index to the index location is also passed to the clock chip as a write to its address register. This keeps the chip's own pointer in step with the router's index.

Two design-time parameters change the variant:

- `CENTURY_PRESET` makes reset load a century byte of 20 at RAM location 0x48 instead of zero.
- `READ_REG` chooses how read data leaves the block. At 0 it is combinational, in the same cycle as the read strobe. At 1 it is registered and appears one cycle later.

Top module: `cmos_port_router`

## Requirements
- R1: `bus_a0` = 0 addresses the index location and `bus_a0` = 1 the data location. A data-location write leaves the stored index unchanged.
- R2: A write to the index location stores `bus_wdata` as the index on that clock edge. An index-location read returns the index last written.
- R3: An index write whose byte is at most 0x0D drives, in the same cycle, `rtc_wr` = 1, `rtc_a0` = 0 and `rtc_wdata` = the byte. An index write of 0x0E or above leaves `rtc_wr` low.
- R4: With index at most 0x0D, a data-location write drives `rtc_wr` = 1, `rtc_a0` = 1 and `rtc_wdata` = the byte in the same cycle. A data-location read drives `rtc_rd` = 1, `rtc_a0` = 1 and returns `rtc_rdata`.
- R5: With index 0x0E or above, data-location accesses write or read RAM location [index], and `rtc_wr` and `rtc_rd` stay low.
- R6: Reset clears the index and every RAM location to 0.
- R7: With `CENTURY_PRESET` = 1, reset loads RAM location 0x48 with 20 (0x14) instead of 0.
- R8: `bus_rdata` is 0 in any cycle without a read. With `READ_REG` = 0 the read value appears in the read cycle. With `READ_REG` = 1 it appears in the next cycle, and is 0 there if no read was made.
- R9: Index-location reads, and cycles with no strobe, assert neither `rtc_wr` nor `rtc_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_a0 | input | 1 | 0 = index location, 1 = data location |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | 8 | Bus write byte |
| bus_rdata | output | 8 | Bus read byte |
| rtc_a0 | output | 1 | Clock chip select: 0 = address register, 1 = data |
| rtc_wr | output | 1 | Clock chip write strobe |
| rtc_rd | output | 1 | Clock chip read strobe |
| rtc_wdata | output | 8 | Byte written to the clock chip |
| rtc_rdata | input | 8 | Byte returned by the clock chip |

## Verification
The following are checked on every cycle:

- the index loads on an index write and holds otherwise;
- low index writes are mirrored to the clock address port;
- RAM-directed or idle cycles never strobe the clock chip;
- read data is zero after a cycle with no read.

Other behaviour needs the bench's scenarios:

- that a byte written to RAM or to the chip comes back on a later read;
- that the index boundary falls exactly between 0x0D and 0x0E;
- the reset contents, including the century preset;
- the one-cycle delay of the registered read variant.

// File: rtl/cmos_port_router.sv
module cmos_port_router #(
  parameter int          DATA_W         = 8,
  parameter int          IDX_W          = 8,
  parameter logic [7:0]  RTC_LAST       = 8'h0D,
  parameter bit          CENTURY_PRESET = 1'b0,
  parameter logic [7:0]  CENTURY_ADDR   = 8'h48,
  parameter logic [7:0]  CENTURY_VAL    = 8'd20,
  parameter bit          READ_REG       = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_a0,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rtc_a0,
  output logic              rtc_wr,
  output logic              rtc_rd,
  output logic [DATA_W-1:0] rtc_wdata,
  input  logic [DATA_W-1:0] rtc_rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] ram [DEPTH];
  logic [DATA_W-1:0] rd_mux;
  logic              idx_low, wd_low, ram_we;

  assign idx_low = idx <= IDX_W'(RTC_LAST);
  assign wd_low  = IDX_W'(bus_wdata) <= IDX_W'(RTC_LAST);
  assign ram_we  = bus_wr & bus_a0 & ~idx_low;

  assign rtc_a0    = bus_a0;
  assign rtc_wdata = bus_wdata;
  assign rtc_wr    = bus_wr & (bus_a0 ? idx_low : wd_low);
  assign rtc_rd    = bus_rd & bus_a0 & idx_low;

  always_ff @(posedge clk) begin
    if (!rst_n)
      idx <= '0;
    else if (bus_wr && !bus_a0)
      idx <= IDX_W'(bus_wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        ram[i] <= (CENTURY_PRESET && i == int'(CENTURY_ADDR)) ? CENTURY_VAL : '0;
    end else if (ram_we) begin
      ram[idx] <= bus_wdata;
    end
  end

  always_comb begin
    if (!bus_rd)      rd_mux = '0;
    else if (!bus_a0) rd_mux = DATA_W'(idx);
    else if (idx_low) rd_mux = rtc_rdata;
    else              rd_mux = ram[idx];
  end

  generate
    if (READ_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_mux;
      end
      assign bus_rdata = rd_q;
    end else begin : g_rd_comb
      assign bus_rdata = rd_mux;
    end
  endgenerate
endmodule

module cmos_port_router_chk #(
  parameter logic [7:0] RTC_LAST = 8'h0D,
  parameter bit         READ_REG = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_a0,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       rtc_a0,
  input logic       rtc_wr,
  input logic       rtc_rd,
  input logic [7:0] rtc_wdata,
  input logic [7:0] idx
);
  p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_a0) |=> idx == $past(bus_wdata));

  p_idx_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && !bus_a0) |=> $stable(idx));

  p_idx_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_a0 && bus_wdata <= RTC_LAST) |-> (rtc_wr && !rtc_a0 && rtc_wdata == bus_wdata));

  p_ram_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_a0 && idx > RTC_LAST) |-> (!rtc_wr && !rtc_rd));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && (!bus_rd || !bus_a0)) |-> (!rtc_wr && !rtc_rd));

  generate
    if (READ_REG) begin : g_reg
      p_rdata_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == 8'h00);
    end else begin : g_comb
      p_rdata_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == 8'h00);
    end
  endgenerate
endmodule

bind cmos_port_router cmos_port_router_chk #(.RTC_LAST(RTC_LAST), .READ_REG(READ_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_a0(bus_a0), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rtc_a0(rtc_a0), .rtc_wr(rtc_wr),
  .rtc_rd(rtc_rd), .rtc_wdata(rtc_wdata), .idx(idx)
);

// File: tb/cmos_port_router_bench.sv
module cmos_port_router_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a0 = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wd = 8'h00;

  logic [7:0] m_rdata, m_rtc_wdata, m_rtc_rdata;
  logic       m_rtc_a0, m_rtc_wr, m_rtc_rd;
  logic [7:0] x_rdata, x_rtc_wdata, x_rtc_rdata;
  logic       x_rtc_a0, x_rtc_wr, x_rtc_rd;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  cmos_port_router u_cmos_port_router (
    .clk(clk), .rst_n(rst_n), .bus_a0(a0), .bus_wr(wr), .bus_rd(rd), .bus_wdata(wd),
    .bus_rdata(m_rdata), .rtc_a0(m_rtc_a0), .rtc_wr(m_rtc_wr), .rtc_rd(m_rtc_rd),
    .rtc_wdata(m_rtc_wdata), .rtc_rdata(m_rtc_rdata));

  cmos_port_router #(.CENTURY_PRESET(1'b1), .READ_REG(1'b1)) u_cmos_port_router_alt (
    .clk(clk), .rst_n(rst_n), .bus_a0(a0), .bus_wr(wr), .bus_rd(rd), .bus_wdata(wd),
    .bus_rdata(x_rdata), .rtc_a0(x_rtc_a0), .rtc_wr(x_rtc_wr), .rtc_rd(x_rtc_rd),
    .rtc_wdata(x_rtc_wdata), .rtc_rdata(x_rtc_rdata));

  // clock chip stubs, one per instance
  logic [7:0] s1_reg [16];
  logic [7:0] s2_reg [16];
  logic [3:0] s1_ptr = 4'd0, s2_ptr = 4'd0;
  initial for (int i = 0; i < 16; i++) begin s1_reg[i] = 8'h00; s2_reg[i] = 8'h00; end
  assign m_rtc_rdata = s1_reg[s1_ptr];
  assign x_rtc_rdata = s2_reg[s2_ptr];
  always @(posedge clk) begin
    if (m_rtc_wr) begin
      if (!m_rtc_a0) s1_ptr <= m_rtc_wdata[3:0];
      else           s1_reg[s1_ptr] <= m_rtc_wdata;
    end
    if (x_rtc_wr) begin
      if (!x_rtc_a0) s2_ptr <= x_rtc_wdata[3:0];
      else           s2_reg[s2_ptr] <= x_rtc_wdata;
    end
  end

  // reference model
  int q_idx;
  int q_ram [256];
  int q_ram2 [256];
  int q_rtc [16];
  int q_ptr;
  int q_alt_rd;

  function automatic int model_rd(bit alt);
    if (!rd) return 0;
    if (!a0) return q_idx;
    if (q_idx <= 13) return q_rtc[q_ptr];
    return alt ? q_ram2[q_idx] : q_ram[q_idx];
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(bit sa0, bit swr, bit srd, logic [7:0] swd, string req);
    int e1, e2, ew, er;
    @(negedge clk);
    a0 = sa0; wr = swr; rd = srd; wd = swd;
    #1;
    e1 = model_rd(1'b0);
    e2 = model_rd(1'b1);
    ew = (swr && (sa0 ? q_idx <= 13 : int'(swd) <= 13)) ? 1 : 0;
    er = (srd && sa0 && q_idx <= 13) ? 1 : 0;
    vectors++;
    chk(req, "bus_rdata", int'(m_rdata), e1);
    chk(req, "alt bus_rdata", int'(x_rdata), q_alt_rd);
    chk(req, "rtc_wr", int'(m_rtc_wr), ew);
    chk(req, "rtc_rd", int'(m_rtc_rd), er);
    chk(req, "alt rtc_wr", int'(x_rtc_wr), ew);
    chk(req, "alt rtc_rd", int'(x_rtc_rd), er);
    if (ew != 0 || er != 0) begin
      chk(req, "rtc_a0", int'(m_rtc_a0), int'(sa0));
      chk(req, "alt rtc_a0", int'(x_rtc_a0), int'(sa0));
    end
    if (ew != 0) begin
      chk(req, "rtc_wdata", int'(m_rtc_wdata), int'(swd));
      chk(req, "alt rtc_wdata", int'(x_rtc_wdata), int'(swd));
    end
    @(posedge clk);
    q_alt_rd = e2;
    if (swr) begin
      if (!sa0) begin
        q_idx = int'(swd);
        if (int'(swd) <= 13) q_ptr = int'(swd[3:0]);
      end else if (q_idx <= 13) begin
        q_rtc[q_ptr] = int'(swd);
      end else begin
        q_ram[q_idx] = int'(swd);
        q_ram2[q_idx] = int'(swd);
      end
    end
  endtask

  task automatic wr_idx(logic [7:0] v, string req); step(1'b0, 1'b1, 1'b0, v, req); endtask
  task automatic wr_dat(logic [7:0] v, string req); step(1'b1, 1'b1, 1'b0, v, req); endtask
  task automatic rd_idx(string req); step(1'b0, 1'b0, 1'b1, 8'h00, req); endtask
  task automatic rd_dat(string req); step(1'b1, 1'b0, 1'b1, 8'h00, req); endtask
  task automatic idle(string req); step(1'b0, 1'b0, 1'b0, 8'h00, req); endtask

  initial begin
    #500us;
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    q_idx = 0; q_ptr = 0; q_alt_rd = 0;
    for (int i = 0; i < 256; i++) begin q_ram[i] = 0; q_ram2[i] = 0; end
    q_ram2[8'h48] = 20;
    for (int i = 0; i < 16; i++) q_rtc[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R6 reset state, R7 century preset on the alternate instance
    rd_idx("R6");
    wr_idx(8'h48, "R7"); rd_dat("R7"); idle("R7");
    wr_idx(8'h0E, "R6"); rd_dat("R6");
    wr_idx(8'hFF, "R6"); rd_dat("R6"); idle("R8");

    // R2 index store and readback
    wr_idx(8'h30, "R2"); rd_idx("R2"); idle("R8");
    wr_idx(8'hC7, "R2"); rd_idx("R2");

    // R3 mirroring at and around the boundary
    wr_idx(8'h00, "R3"); wr_idx(8'h0D, "R3"); wr_idx(8'h0E, "R3"); wr_idx(8'h05, "R3");

    // R4 clock chip data path
    wr_dat(8'hA5, "R4"); rd_dat("R4"); idle("R9");
    wr_idx(8'h0D, "R4"); wr_dat(8'h3C, "R4"); rd_dat("R4");
    wr_idx(8'h05, "R4"); rd_dat("R4");

    // R5 RAM path, clock chip untouched
    wr_idx(8'h0E, "R5"); wr_dat(8'h11, "R5");
    wr_idx(8'hFF, "R5"); wr_dat(8'h22, "R5");
    wr_idx(8'h80, "R5"); wr_dat(8'h33, "R5"); rd_dat("R5");
    wr_idx(8'h0E, "R5"); rd_dat("R5");
    wr_idx(8'hFF, "R5"); rd_dat("R5");
    wr_idx(8'h05, "R5"); rd_dat("R5");

    // R1 data write leaves index intact
    wr_idx(8'h60, "R1"); wr_dat(8'h77, "R1"); rd_idx("R1"); rd_dat("R1");
    wr_idx(8'h07, "R1"); wr_dat(8'h99, "R1"); rd_idx("R1");

    // R8 / R9 idle and index reads
    repeat (4) idle("R9");
    rd_idx("R9"); idle("R8"); rd_dat("R8"); idle("R8");

    // R7 century byte overwritten behaves as plain RAM
    wr_idx(8'h48, "R7"); wr_dat(8'h21, "R7"); rd_dat("R7"); idle("R7");

    // mixed traffic across both paths
    for (int n = 0; n < 600; n++) begin
      int k;
      logic [7:0] v;
      k = $urandom_range(0, 4);
      v = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 16)) : 8'($urandom);
      case (k)
        0: wr_idx(v, "R2");
        1: wr_dat(v, "R5");
        2: rd_dat("R4");
        3: rd_idx("R2");
        default: idle("R8");
      endcase
    end
    idle("R8");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule